// File: doc/BRIEF.md
# Dual-Palette Colour Mapper with Blink Effects

This block sits in a display pixel pipeline between the pixel fetch logic and the panel driver. Each cycle it may accept one pixel word together with a valid flag and returns one 24-bit RGB colour two clocks later.

In indexed mode the low eight bits of the pixel select an entry in one of two 256-entry colour tables. A write port fills either table. A palette-select bit chooses the table in use, and the choice only changes on a frame-start pulse. In the 16-bit and 24-bit direct modes the tables are skipped and the pixel word itself supplies the colour.

Blink effects apply while blink is enabled and the blink phase input is high. In indexed mode the table address can be combined with an operand by AND, OR or XOR, and a key compare can limit the blink to one index value. In direct modes the same three logic operations act on the 24-bit colour. In every mode the colour can also be replaced by a background colour, halved, brightened or inverted.

Top module: `clut_blink`

## Requirements
- R1: With depth code 2'b00 (indexed) and blink inactive, the output colour is the entry of the active table addressed by pixel bits [7:0].
- R2: `out_valid` copies `pix_valid` exactly two clock edges later and is low after reset. `out_rgb` holds its value on cycles that carry no valid pixel.
- R3: The active table (0 or 1) takes the value of `pal_sel` only at a clock edge where `frame_start` is high. A pixel sampled at that same edge still uses the previous table.
- R4: A write with `wr_en` high stores `wr_data` at `wr_addr` in the table chosen by `wr_tbl`. A pixel that reads the same entry at the same edge returns the old contents.
- R5: Blink is active when `blink_en` and `blink_phase` are both high. In indexed mode, blink mode 3'b000/3'b001/3'b010 replaces the table address with index AND, OR or XOR `blink_arg[7:0]`.
- R6: In indexed mode with `key_en` high, blink acts only on pixels whose index equals `key_idx`. Other pixels are unchanged.
- R7: Depth code 2'b01 maps pixel bits [15:0] as 5-6-5 red-green-blue, widening each field to 8 bits by repeating its top bits. Depth codes 2'b10 and 2'b11 pass pixel bits [23:0] through. Neither path reads the tables.
- R8: In the direct modes, blink modes 3'b000/3'b001/3'b010 apply AND, OR or XOR with `blink_arg` to the 24-bit colour.
- R9: In any depth, when blink is active: mode 3'b011 outputs `blink_arg` (background), 3'b100 shifts each 8-bit component right by one, 3'b101 sets the top bit of each component, and 3'b110 inverts the colour.
- R10: With blink inactive (either `blink_en` or `blink_phase` low), or with mode 3'b111, the colour is not changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_tbl | input | 1 | Table chosen for the write |
| wr_addr | input | 8 | Table entry to write |
| wr_data | input | 24 | RGB value to store |
| pal_sel | input | 1 | Requested active table |
| frame_start | input | 1 | Frame boundary pulse; loads `pal_sel` |
| depth | input | 2 | Pixel format: 00 indexed, 01 5-6-5, 1x 24-bit |
| pix_valid | input | 1 | Pixel word is valid |
| pix_in | input | 24 | Pixel word |
| blink_en | input | 1 | Blink enable |
| blink_phase | input | 1 | Blink phase, high = blinked |
| blink_mode | input | 3 | Blink operation code |
| blink_arg | input | 24 | Blink operand / background colour |
| key_en | input | 1 | Limit indexed blink to one index |
| key_idx | input | 8 | Index value that blinks when limited |
| out_valid | output | 1 | Output colour is valid |
| out_rgb | output | 24 | Output colour, red in [23:16] |

## Verification
Every pixel result is due two clock edges after the edge that samples the pixel. The bench drives a pixel on a falling edge and drops its valid on the next falling edge, where it also checks that `out_valid` is still low. It reads the colour on the falling edge after that. Palette switches are due at the edge that samples `frame_start`, and table writes are visible to a pixel sampled one edge after the write. The palette and write-collision tests therefore place the pixel in the same cycle as the write or pulse, and then again in the cycle after.

// File: rtl/clut_pkg.sv
`timescale 1ns/1ps
// Shared constants and codes for the colour mapper.
// Assumes three equal colour components packed red-high.
package clut_pkg;
    localparam int COLOR_W = 24;
    localparam int IDX_W   = 8;
    localparam int NUM_PAL = 2;
    localparam int COMP_W  = COLOR_W / 3;
    localparam int DEPTH_W = 2;
    localparam int MODE_W  = 3;

    typedef enum logic [DEPTH_W-1:0] {
        DEPTH_IDX  = 2'b00,
        DEPTH_565  = 2'b01,
        DEPTH_24   = 2'b10,
        DEPTH_24B  = 2'b11
    } depth_e;

    typedef enum logic [MODE_W-1:0] {
        BLK_AND    = 3'b000,
        BLK_OR     = 3'b001,
        BLK_XOR    = 3'b010,
        BLK_BG     = 3'b011,
        BLK_DIM    = 3'b100,
        BLK_BRIGHT = 3'b101,
        BLK_REV    = 3'b110,
        BLK_NONE   = 3'b111
    } blink_e;
endpackage

// File: rtl/clut_ram.sv
`timescale 1ns/1ps
// One colour table: single write port, one registered read port.
// Assumes a write and a read of the same entry at one edge returns the old data.
module clut_ram #(
    parameter int DATA_W = 24,
    parameter int ADDR_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Table storage update on the write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read; sees contents from before this edge's write.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= mem[raddr];
    end
endmodule

// File: rtl/clut_front.sv
`timescale 1ns/1ps
// First-stage combinational logic: blink qualification, table address
// modification and direct-colour expansion.
// Assumes pixel word is red-high and indexed pixels use the low IDX_W bits.
module clut_front
    import clut_pkg::*;
(
    input  logic [DEPTH_W-1:0] depth,
    input  logic [COLOR_W-1:0] pix,
    input  logic               blink_en,
    input  logic               blink_phase,
    input  logic [MODE_W-1:0]  mode,
    input  logic [COLOR_W-1:0] arg,
    input  logic               key_en,
    input  logic [IDX_W-1:0]   key_idx,
    output logic               lut_mode,
    output logic               act,
    output logic [IDX_W-1:0]   lut_addr,
    output logic [COLOR_W-1:0] direct_rgb
);
    localparam int R5 = 5;
    localparam int G6 = 6;
    localparam int B5 = 5;

    logic [IDX_W-1:0] idx;
    logic             key_ok;
    logic [R5-1:0]    r_f;
    logic [G6-1:0]    g_f;
    logic [B5-1:0]    b_f;

    assign idx      = pix[IDX_W-1:0];
    assign lut_mode = (depth_e'(depth) == DEPTH_IDX);
    assign key_ok   = !lut_mode || !key_en || (idx == key_idx);
    assign act      = blink_en && blink_phase && key_ok;

    // Table address with optional logic blink applied.
    always_comb begin
        lut_addr = idx;
        if (act) begin
            case (blink_e'(mode))
                BLK_AND: lut_addr = idx & arg[IDX_W-1:0];
                BLK_OR:  lut_addr = idx | arg[IDX_W-1:0];
                BLK_XOR: lut_addr = idx ^ arg[IDX_W-1:0];
                default: lut_addr = idx;
            endcase
        end
    end

    assign r_f = pix[15:11];
    assign g_f = pix[10:5];
    assign b_f = pix[4:0];

    // Direct colour: widen 5-6-5 by repeating top bits, else pass through.
    always_comb begin
        if (depth_e'(depth) == DEPTH_565)
            direct_rgb = {r_f, r_f[R5-1 -: COMP_W-R5],
                          g_f, g_f[G6-1 -: COMP_W-G6],
                          b_f, b_f[B5-1 -: COMP_W-B5]};
        else
            direct_rgb = pix;
    end
endmodule

// File: rtl/clut_xform.sv
`timescale 1ns/1ps
// Second-stage colour transform for blink effects.
// Assumes logic blink modes were already folded into the address in indexed mode.
module clut_xform
    import clut_pkg::*;
(
    input  logic [COLOR_W-1:0] base,
    input  logic               act,
    input  logic               lut_mode,
    input  logic [MODE_W-1:0]  mode,
    input  logic [COLOR_W-1:0] arg,
    output logic [COLOR_W-1:0] rgb
);
    logic [COLOR_W-1:0] dim_v;
    logic [COLOR_W-1:0] bright_v;

    for (genvar c = 0; c < 3; c++) begin : g_comp
        assign dim_v[c*COMP_W +: COMP_W]    = base[c*COMP_W +: COMP_W] >> 1;
        assign bright_v[c*COMP_W +: COMP_W] = base[c*COMP_W +: COMP_W]
                                              | (COMP_W'(1) << (COMP_W-1));
    end

    // Pick the blink result for the active mode.
    always_comb begin
        rgb = base;
        if (act) begin
            case (blink_e'(mode))
                BLK_AND:    rgb = lut_mode ? base : (base & arg);
                BLK_OR:     rgb = lut_mode ? base : (base | arg);
                BLK_XOR:    rgb = lut_mode ? base : (base ^ arg);
                BLK_BG:     rgb = arg;
                BLK_DIM:    rgb = dim_v;
                BLK_BRIGHT: rgb = bright_v;
                BLK_REV:    rgb = ~base;
                default:    rgb = base;
            endcase
        end
    end
endmodule

// File: rtl/clut_blink.sv
`timescale 1ns/1ps
// Two-stage colour mapper: pixel index or direct colour in, RGB out,
// two selectable tables, blink effects.
// Assumes the palette bit only changes meaningfully at frame start.
module clut_blink
    import clut_pkg::*;
#(
    parameter int TBL_SEL_W = $clog2(NUM_PAL)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [TBL_SEL_W-1:0] wr_tbl,
    input  logic [IDX_W-1:0]     wr_addr,
    input  logic [COLOR_W-1:0]   wr_data,
    input  logic [TBL_SEL_W-1:0] pal_sel,
    input  logic                 frame_start,
    input  logic [DEPTH_W-1:0]   depth,
    input  logic                 pix_valid,
    input  logic [COLOR_W-1:0]   pix_in,
    input  logic                 blink_en,
    input  logic                 blink_phase,
    input  logic [MODE_W-1:0]    blink_mode,
    input  logic [COLOR_W-1:0]   blink_arg,
    input  logic                 key_en,
    input  logic [IDX_W-1:0]     key_idx,
    output logic                 out_valid,
    output logic [COLOR_W-1:0]   out_rgb
);
    logic [TBL_SEL_W-1:0] pal_active;
    logic                 f_lut_mode;
    logic                 f_act;
    logic [IDX_W-1:0]     f_addr;
    logic [COLOR_W-1:0]   f_direct;

    logic                 s1_valid;
    logic                 s1_lut_mode;
    logic                 s1_act;
    logic [MODE_W-1:0]    s1_mode;
    logic [COLOR_W-1:0]   s1_arg;
    logic [COLOR_W-1:0]   s1_direct;
    logic [TBL_SEL_W-1:0] s1_pal;

    logic [COLOR_W-1:0]   rd_data [NUM_PAL];
    logic [COLOR_W-1:0]   s2_base;
    logic [COLOR_W-1:0]   s2_rgb;

    // Active palette loads only on a frame-start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)           pal_active <= '0;
        else if (frame_start) pal_active <= pal_sel;
    end

    clut_front u_front (
        .depth       (depth),
        .pix         (pix_in),
        .blink_en    (blink_en),
        .blink_phase (blink_phase),
        .mode        (blink_mode),
        .arg         (blink_arg),
        .key_en      (key_en),
        .key_idx     (key_idx),
        .lut_mode    (f_lut_mode),
        .act         (f_act),
        .lut_addr    (f_addr),
        .direct_rgb  (f_direct)
    );

    for (genvar t = 0; t < NUM_PAL; t++) begin : g_tbl
        clut_ram #(.DATA_W(COLOR_W), .ADDR_W(IDX_W)) u_ram (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en && (wr_tbl == TBL_SEL_W'(t))),
            .waddr (wr_addr),
            .wdata (wr_data),
            .raddr (f_addr),
            .rdata (rd_data[t])
        );
    end

    // Stage 1: carry control and direct colour beside the table read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid    <= 1'b0;
            s1_lut_mode <= 1'b0;
            s1_act      <= 1'b0;
            s1_mode     <= '0;
            s1_arg      <= '0;
            s1_direct   <= '0;
            s1_pal      <= '0;
        end else begin
            s1_valid    <= pix_valid;
            s1_lut_mode <= f_lut_mode;
            s1_act      <= f_act;
            s1_mode     <= blink_mode;
            s1_arg      <= blink_arg;
            s1_direct   <= f_direct;
            s1_pal      <= pal_active;
        end
    end

    assign s2_base = s1_lut_mode ? rd_data[s1_pal] : s1_direct;

    clut_xform u_xform (
        .base     (s2_base),
        .act      (s1_act),
        .lut_mode (s1_lut_mode),
        .mode     (s1_mode),
        .arg      (s1_arg),
        .rgb      (s2_rgb)
    );

    // Stage 2: register the result; colour holds on idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_rgb   <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) out_rgb <= s2_rgb;
        end
    end
endmodule

// File: rtl/clut_blink_chk.sv
`timescale 1ns/1ps
// Property checker for clut_blink, attached by bind.
// Assumes synchronous active-low reset.
module clut_blink_chk
    import clut_pkg::*;
#(
    parameter int TBL_SEL_W = 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 pix_valid,
    input logic [COLOR_W-1:0]   pix_in,
    input logic [DEPTH_W-1:0]   depth,
    input logic                 blink_en,
    input logic [TBL_SEL_W-1:0] pal_sel,
    input logic                 frame_start,
    input logic [TBL_SEL_W-1:0] pal_active,
    input logic                 s1_valid,
    input logic                 out_valid,
    input logic [COLOR_W-1:0]   out_rgb
);
    logic [1:0] since_rst;

    // Count edges since reset release, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= 2'd0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (out_valid == $past(pix_valid, 2)));

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> $stable(out_rgb));

    a_r3_no_midframe_switch: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(pal_active));

    a_r3_frame_load: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (pal_active == $past(pal_sel)));

    a_r7_direct_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2 && $past(pix_valid, 2) && $past(depth, 2) == 2'b10
         && !$past(blink_en, 2)) |-> (out_rgb == $past(pix_in, 2)));
endmodule

bind clut_blink clut_blink_chk #(.TBL_SEL_W(TBL_SEL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_valid   (pix_valid),
    .pix_in      (pix_in),
    .depth       (depth),
    .blink_en    (blink_en),
    .pal_sel     (pal_sel),
    .frame_start (frame_start),
    .pal_active  (pal_active),
    .s1_valid    (s1_valid),
    .out_valid   (out_valid),
    .out_rgb     (out_rgb)
);

// File: tb/tb_clut_blink.sv
`timescale 1ns/1ps
// Directed bench for clut_blink: one task per scenario.
module tb_clut_blink;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, wr_tbl, pal_sel, frame_start, pix_valid;
    logic [7:0]  wr_addr, key_idx;
    logic [23:0] wr_data, pix_in, blink_arg;
    logic [1:0]  depth;
    logic        blink_en, blink_phase, key_en;
    logic [2:0]  blink_mode;
    logic        out_valid;
    logic [23:0] out_rgb;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [23:0] mdl [2][256];

    always #10 clk = ~clk;

    clut_blink dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tbl(wr_tbl),
        .wr_addr(wr_addr), .wr_data(wr_data), .pal_sel(pal_sel),
        .frame_start(frame_start), .depth(depth), .pix_valid(pix_valid),
        .pix_in(pix_in), .blink_en(blink_en), .blink_phase(blink_phase),
        .blink_mode(blink_mode), .blink_arg(blink_arg), .key_en(key_en),
        .key_idx(key_idx), .out_valid(out_valid), .out_rgb(out_rgb)
    );

    function automatic logic [23:0] gen(int t, int i);
        return {8'(i) ^ (t != 0 ? 8'h5A : 8'h00), 8'(i * 3), 8'(255 - i)};
    endfunction

    function automatic logic [23:0] exp565(logic [15:0] p);
        return {p[15:11], p[15:13], p[10:5], p[10:9], p[4:0], p[4:2]};
    endfunction

    task automatic check(string req, logic [23:0] act, logic [23:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, expv);
        end
    endtask

    // Drive one pixel, confirm two-edge latency, return the colour.
    task automatic run_pix(input logic [1:0] d, input logic [23:0] p,
                           input string req, input logic [23:0] expv);
        @(negedge clk);
        depth = d; pix_in = p; pix_valid = 1'b1;
        @(negedge clk);
        pix_valid = 1'b0; wr_en = 1'b0; frame_start = 1'b0;
        check({req, "/R2 early valid"}, {23'd0, out_valid}, 24'd0);
        @(negedge clk);
        check({req, "/R2 valid"}, {23'd0, out_valid}, 24'd1);
        check(req, out_rgb, expv);
    endtask

    task automatic wr(input logic t, input logic [7:0] a, input logic [23:0] dv);
        @(negedge clk);
        wr_en = 1'b1; wr_tbl = t; wr_addr = a; wr_data = dv;
        mdl[t][a] = dv;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic blink(input logic en, input logic ph, input logic [2:0] m,
                         input logic [23:0] a);
        blink_en = en; blink_phase = ph; blink_mode = m; blink_arg = a;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 reset valid", {23'd0, out_valid}, 24'd0);
        check("R2 reset rgb", out_rgb, 24'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_fill();
        for (int t = 0; t < 2; t++)
            for (int i = 0; i < 256; i++) wr(t[0], 8'(i), gen(t, i));
    endtask

    task automatic t_lut_basic();
        blink(0, 0, 3'b000, 24'd0);
        run_pix(2'b00, 24'hABCD00, "R1 idx0", mdl[0][0]);
        run_pix(2'b00, 24'h0000FF, "R1 idx255", mdl[0][255]);
        run_pix(2'b00, 24'hFFFF4D, "R1 idx77 upper ignored", mdl[0][77]);
    endtask

    task automatic t_rdw();
        logic [23:0] old;
        old = mdl[0][5];
        @(negedge clk);
        wr_en = 1'b1; wr_tbl = 1'b0; wr_addr = 8'd5; wr_data = 24'hC0FFEE;
        depth = 2'b00; pix_in = 24'd5; pix_valid = 1'b1;
        mdl[0][5] = 24'hC0FFEE;
        @(negedge clk);
        wr_en = 1'b0; pix_valid = 1'b0;
        @(negedge clk);
        check("R4 same-edge read old", out_rgb, old);
        run_pix(2'b00, 24'd5, "R4 new value", 24'hC0FFEE);
        wr(1'b1, 8'd6, 24'h123321);
        run_pix(2'b00, 24'd6, "R4 other table untouched", mdl[0][6]);
    endtask

    task automatic t_palette();
        pal_sel = 1'b1;
        run_pix(2'b00, 24'd9, "R3 no pulse keeps table0", mdl[0][9]);
        @(negedge clk);
        frame_start = 1'b1; depth = 2'b00; pix_in = 24'd9; pix_valid = 1'b1;
        @(negedge clk);
        frame_start = 1'b0; pix_valid = 1'b0;
        @(negedge clk);
        check("R3 pulse-edge pixel old table", out_rgb, mdl[0][9]);
        run_pix(2'b00, 24'd9, "R3 table1 after pulse", mdl[1][9]);
        pal_sel = 1'b0;
        run_pix(2'b00, 24'd6, "R3 held until next pulse", mdl[1][6]);
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        run_pix(2'b00, 24'd9, "R3 back to table0", mdl[0][9]);
    endtask

    task automatic t_addr_blink();
        blink(1, 1, 3'b000, 24'h00000F);
        run_pix(2'b00, 24'h3C, "R5 AND", mdl[0][8'h0C]);
        blink(1, 1, 3'b001, 24'h000080);
        run_pix(2'b00, 24'h05, "R5 OR", mdl[0][8'h85]);
        blink(1, 1, 3'b010, 24'h0000FF);
        run_pix(2'b00, 24'h11, "R5 XOR", mdl[0][8'hEE]);
        blink(1, 0, 3'b010, 24'h0000FF);
        run_pix(2'b00, 24'h11, "R10 phase low", mdl[0][8'h11]);
        blink(0, 1, 3'b010, 24'h0000FF);
        run_pix(2'b00, 24'h11, "R10 enable low", mdl[0][8'h11]);
        blink(1, 1, 3'b111, 24'h0000FF);
        run_pix(2'b00, 24'h11, "R10 mode none", mdl[0][8'h11]);
    endtask

    task automatic t_key();
        key_en = 1'b1; key_idx = 8'h20;
        blink(1, 1, 3'b010, 24'h000001);
        run_pix(2'b00, 24'h20, "R6 key match blinks", mdl[0][8'h21]);
        run_pix(2'b00, 24'h21, "R6 non-key unchanged", mdl[0][8'h21]);
        blink(1, 1, 3'b110, 24'h0);
        run_pix(2'b00, 24'h30, "R6 non-key no reverse", mdl[0][8'h30]);
        key_en = 1'b0;
    endtask

    task automatic t_bypass();
        blink(0, 0, 3'b000, 24'd0);
        run_pix(2'b01, 24'h00F800, "R7 565 red", 24'hFF0000);
        run_pix(2'b01, 24'h0007E0, "R7 565 green", 24'h00FF00);
        run_pix(2'b01, 24'hFF1234, "R7 565 mixed", exp565(16'h1234));
        run_pix(2'b10, 24'h123456, "R7 24-bit", 24'h123456);
        run_pix(2'b11, 24'h000000, "R7 24-bit alt code", 24'h000000);
        blink(1, 1, 3'b010, 24'h00FF00);
        run_pix(2'b10, 24'h123456, "R8 XOR direct", 24'h12CB56);
        blink(1, 1, 3'b000, 24'hF0F0F0);
        run_pix(2'b10, 24'h123456, "R8 AND direct", 24'h103050);
        blink(1, 1, 3'b001, 24'h0F0000);
        run_pix(2'b01, 24'h00F800, "R8 OR direct 565", 24'hFF0000);
    endtask

    task automatic t_effects();
        blink(1, 1, 3'b011, 24'h445566);
        run_pix(2'b00, 24'h40, "R9 background", 24'h445566);
        blink(1, 1, 3'b100, 24'h0);
        run_pix(2'b10, 24'h80FF02, "R9 dim", 24'h407F01);
        blink(1, 1, 3'b101, 24'h0);
        run_pix(2'b10, 24'h102030, "R9 bright", 24'h90A0B0);
        blink(1, 1, 3'b110, 24'h0);
        run_pix(2'b00, 24'h41, "R9 reverse", ~mdl[0][8'h41]);
        blink(1, 1, 3'b100, 24'h0);
        run_pix(2'b00, 24'h42, "R9 dim indexed",
                {mdl[0][8'h42][23:16] >> 1, mdl[0][8'h42][15:8] >> 1,
                 mdl[0][8'h42][7:0] >> 1});
        blink(0, 0, 3'b000, 24'h0);
    endtask

    // Scenario sequence.
    initial begin
        wr_en = 0; wr_tbl = 0; wr_addr = 0; wr_data = 0; pal_sel = 0;
        frame_start = 0; depth = 0; pix_valid = 0; pix_in = 0;
        blink_en = 0; blink_phase = 0; blink_mode = 0; blink_arg = 0;
        key_en = 0; key_idx = 0;
        t_reset();
        t_fill();
        t_lut_basic();
        t_rdw();
        t_palette();
        t_addr_blink();
        t_key();
        t_bypass();
        t_effects();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule